// File: doc/BRIEF.md
# Daisy-Chained FIFO Depth Expander

This block lets several identical synchronous FIFO nodes share one write stream and one read stream so that together they act as one buffer whose depth is the sum of theirs. Two ownership tokens circulate around a ring of nodes: a write turn and a read turn. A node that owns the write turn stores incoming words. When it stores a word into its highest physical slot, it gives up the turn and emits a one-cycle low pulse to its successor. The read turn moves the same way, triggered by a read from the highest slot. Because both tokens follow the same ring, words leave the chain in the order they entered it.

Each node learns its role at the first clock edge after reset from three strap inputs. When the lead strap and both expansion inputs are all low, the node works alone: it always owns both turns, and its shared write-expansion pin shows a half-full indication instead of a token pulse. The top module is a wrapper that chains three nodes on a single clock, wraps the last node's expansion outputs back to the first node, and combines the per-node status into composite flags.

Top module: `fifo_chain3`

## Requirements
- R1: During reset and afterwards with no traffic, the composite outputs are: full_n=1, empty_n=0, almost_empty_n=0, almost_full_n=1 and dout=0.
- R2: Words are read out of the chain in the order they were accepted. The chain accepts exactly NODES*DEPTH words (12 by default) before it reports full.
- R3: After a node writes its last physical slot, composite full_n is low for exactly one cycle while the write turn is in transit, and is high again in the following cycle.
- R4: After a node reads its last physical slot, composite empty_n is low for exactly one cycle while the read turn is in transit, provided the next node holds data.
- R5: A write presented while full_n is low is dropped and does not change the stored contents. A read presented while empty_n is low is dropped.
- R6: A chained node drives wxo_hf_n low for exactly one cycle after it writes its last slot. It then refuses writes (full_n=0) until a low cycle arrives on its wxi_n, and it accepts writes again from the next cycle.
- R7: A chained node drives rxo_n low for exactly one cycle after it reads its last slot, and it then holds empty_n=0 until a low cycle arrives on its rxi_n.
- R8: A node whose lead_n, wxi_n and rxi_n are all low at the first edge after reset is in single mode. In single mode it always owns both turns, rxo_n stays high even when its pointers wrap, and wxo_hf_n is low exactly while it holds more than DEPTH/2 words.
- R9: Each node reports full_n=0 when it does not own the write turn or its storage is full, and empty_n=0 when it does not own the read turn or it holds no words. The composite flags are the OR of the per-node active-low flags. A node's almost_empty_n is low when it holds at most AE_LVL words, and its almost_full_n is low when it holds at least DEPTH-AF_LVL words.
- R10: dout shows the word from the node that served the most recent read. Each node's output register is cleared by reset and holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all nodes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| din | input | W | Write data |
| rd_en | input | 1 | Read request |
| dout | output | W | Read data from the node that served the last read |
| full_n | output | 1 | Composite: low when no node can accept a write |
| empty_n | output | 1 | Composite: low when no node can supply a read |
| almost_full_n | output | 1 | Composite almost-full, active low |
| almost_empty_n | output | 1 | Composite almost-empty, active low |

## Verification
The chain is first filled with writes only, which shows the capacity and the one-cycle write-turn gaps at fixed cycle positions. It is then emptied with reads only, which shows the read-turn gaps and the word order. A phase with simultaneous reads and writes, starting from a partly filled ring, moves both tokens around the ring while they stay apart, so it separates a correct turn order from one that would reorder words. A standalone single-mode node and a standalone lead node with bench-driven expansion inputs expose the pulse width, the turn release and reacquisition, the half-full indication and the absence of read pulses on pointer wrap.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic {
    MODE_CHAIN  = 1'b0,
    MODE_SINGLE = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/chain_mode_lock.sv
module chain_mode_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lead_n,
  input  logic wxi_n,
  input  logic rxi_n,
  output logic locked,
  output logic single
);
  logic locked_q, locked_d;
  logic single_q, single_d;

  always_comb begin
    locked_d = 1'b1;
    single_d = locked_q ? single_q : (~lead_n & ~wxi_n & ~rxi_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      single_q <= 1'b0;
    end else begin
      locked_q <= locked_d;
      single_q <= single_d;
    end
  end

  assign locked = locked_q;
  assign single = single_q;
endmodule

// File: rtl/chain_turn.sv
module chain_turn (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic lead,
  input  logic single,
  input  logic pass_in,
  input  logic last_access,
  output logic own,
  output logic pass_n
);
  logic own_q, own_d;
  logic pass_q_n, pass_d_n;

  always_comb begin
    own_d = own_q;
    if (!locked)                      own_d = lead;
    else if (!single && pass_in)      own_d = 1'b1;
    else if (!single && last_access)  own_d = 1'b0;
    pass_d_n = ~(locked & ~single & last_access);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= 1'b0;
      pass_q_n <= 1'b1;
    end else begin
      own_q    <= own_d;
      pass_q_n <= pass_d_n;
    end
  end

  assign own    = single | (locked ? own_q : lead);
  assign pass_n = pass_q_n;

  // R6 / R7: a turn pulse never lasts two cycles
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_q_n |=> pass_q_n);
  // R6 / R7: a chained node gives up its turn after its last-slot access
  assert_turn_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !single && last_access && !pass_in) |=> !own);
endmodule

// File: rtl/chain_store.sv
module chain_store #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ok,
  input  logic         rd_ok,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic         wr_fire,
  output logic         rd_fire,
  output logic         wr_last,
  output logic         rd_last,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] TOP = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  q_q, q_d;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_fire = wr_en & wr_ok & ~full;
  assign rd_fire = rd_en & rd_ok & ~empty;
  assign wr_last = wr_fire & (wp_q == TOP);
  assign rd_last = rd_fire & (rp_q == TOP);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    q_d   = q_q;
    if (wr_fire) wp_d = (wp_q == TOP) ? '0 : wp_q + 1'b1;
    if (rd_fire) begin
      rp_d = (rp_q == TOP) ? '0 : rp_q + 1'b1;
      q_d  = mem[rp_q];
    end
    if (wr_fire && !rd_fire) cnt_d = cnt_q + 1'b1;
    if (rd_fire && !wr_fire) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      q_q   <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp_q] <= din;
  end

  assign dout  = q_q;
  assign count = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ok && !full && !(rd_en && rd_ok)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_ok) |=> $stable(q_q));
endmodule

// File: rtl/chain_node.sv
module chain_node
  import chain_pkg::*;
#(
  parameter int W      = 8,
  parameter int DEPTH  = 4,
  parameter int AE_LVL = 1,
  parameter int AF_LVL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lead_n,
  input  logic         wxi_n,
  input  logic         rxi_n,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  input  logic         rd_en,
  output logic [W-1:0] dout,
  output logic         full_n,
  output logic         empty_n,
  output logic         almost_full_n,
  output logic         almost_empty_n,
  output logic         wxo_hf_n,
  output logic         rxo_n,
  output logic         wr_turn,
  output logic         rd_turn,
  output logic         rd_fire
);
  localparam int CW = $clog2(DEPTH+1);

  logic locked, single;
  chain_mode_e mode;
  logic [CW-1:0] count;
  logic wr_fire, wr_last, rd_last, full, empty;
  logic wpass_n, rpass_n;

  chain_mode_lock u_mode (
    .clk(clk), .rst_n(rst_n), .lead_n(lead_n), .wxi_n(wxi_n), .rxi_n(rxi_n),
    .locked(locked), .single(single)
  );

  chain_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_turn), .rd_ok(rd_turn),
    .wr_en(wr_en), .rd_en(rd_en), .din(din), .dout(dout), .count(count),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wr_last(wr_last), .rd_last(rd_last),
    .full(full), .empty(empty)
  );

  chain_turn u_wturn (
    .clk(clk), .rst_n(rst_n), .locked(locked), .lead(~lead_n), .single(single),
    .pass_in(~wxi_n), .last_access(wr_last), .own(wr_turn), .pass_n(wpass_n)
  );

  chain_turn u_rturn (
    .clk(clk), .rst_n(rst_n), .locked(locked), .lead(~lead_n), .single(single),
    .pass_in(~rxi_n), .last_access(rd_last), .own(rd_turn), .pass_n(rpass_n)
  );

  assign mode           = single ? MODE_SINGLE : MODE_CHAIN;
  assign full_n         = wr_turn & ~full;
  assign empty_n        = rd_turn & ~empty;
  assign almost_empty_n = (count > CW'(AE_LVL));
  assign almost_full_n  = (count < CW'(DEPTH - AF_LVL));
  assign wxo_hf_n       = (mode == MODE_SINGLE) ? ~(count > CW'(DEPTH/2)) : wpass_n;
  assign rxo_n          = rpass_n;

  // R8: a single-mode node never emits a read token
  assert_single_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> rxo_n);
  // R6: a write that is refused leaves the turn state unchanged
  assert_no_write_pulse_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> wpass_n);
endmodule

// File: rtl/fifo_chain3.sv
module fifo_chain3 #(
  parameter int W      = 8,
  parameter int DEPTH  = 4,
  parameter int NODES  = 3,
  parameter int AE_LVL = 1,
  parameter int AF_LVL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  input  logic         rd_en,
  output logic [W-1:0] dout,
  output logic         full_n,
  output logic         empty_n,
  output logic         almost_full_n,
  output logic         almost_empty_n
);
  localparam int SW = (NODES > 1) ? $clog2(NODES) : 1;

  logic [W-1:0]     q_arr [NODES];
  logic [NODES-1:0] f_n, e_n, af_n, ae_n, wxo, rxo, wturn, rturn, rfire;
  logic [SW-1:0]    sel_q, sel_d;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    localparam int PREV = (i + NODES - 1) % NODES;
    chain_node #(.W(W), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) u_node (
      .clk(clk), .rst_n(rst_n),
      .lead_n((i != 0) ? 1'b1 : 1'b0),
      .wxi_n(wxo[PREV]), .rxi_n(rxo[PREV]),
      .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(q_arr[i]),
      .full_n(f_n[i]), .empty_n(e_n[i]),
      .almost_full_n(af_n[i]), .almost_empty_n(ae_n[i]),
      .wxo_hf_n(wxo[i]), .rxo_n(rxo[i]),
      .wr_turn(wturn[i]), .rd_turn(rturn[i]), .rd_fire(rfire[i])
    );
  end

  always_comb begin
    sel_d = sel_q;
    for (int i = 0; i < NODES; i++) begin
      if (rfire[i]) sel_d = SW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign dout           = q_arr[sel_q];
  assign full_n         = |f_n;
  assign empty_n        = |e_n;
  assign almost_full_n  = |af_n;
  assign almost_empty_n = |ae_n;

  assert_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wturn));
  assert_one_reader_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rturn));
  assert_one_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rfire));
endmodule

// File: tb/test_fifo_chain3.sv
`timescale 1ns/1ps
module test_fifo_chain3;
  localparam int W = 8;
  localparam int DEPTH = 4;
  localparam int NODES = 3;
  localparam int CAP = DEPTH * NODES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // chain under test
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic full_n, empty_n, af_n, ae_n;

  fifo_chain3 #(.W(W), .DEPTH(DEPTH), .NODES(NODES)) i_fifo_chain3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .full_n(full_n), .empty_n(empty_n),
    .almost_full_n(af_n), .almost_empty_n(ae_n)
  );

  // standalone single-mode node
  logic s_wr = 1'b0, s_rd = 1'b0;
  logic [W-1:0] s_din = '0, s_dout;
  logic s_full_n, s_empty_n, s_af_n, s_ae_n, s_hf_n, s_rxo_n, s_wt, s_rt, s_rf;
  chain_node #(.W(W), .DEPTH(DEPTH)) i_solo (
    .clk(clk), .rst_n(rst_n), .lead_n(1'b0), .wxi_n(1'b0), .rxi_n(1'b0),
    .wr_en(s_wr), .din(s_din), .rd_en(s_rd), .dout(s_dout),
    .full_n(s_full_n), .empty_n(s_empty_n), .almost_full_n(s_af_n),
    .almost_empty_n(s_ae_n), .wxo_hf_n(s_hf_n), .rxo_n(s_rxo_n),
    .wr_turn(s_wt), .rd_turn(s_rt), .rd_fire(s_rf)
  );

  // standalone lead node in chain mode, expansion inputs driven by the bench
  logic l_wr = 1'b0, l_rd = 1'b0, l_wxi = 1'b1, l_rxi = 1'b1;
  logic [W-1:0] l_din = '0, l_dout;
  logic l_full_n, l_empty_n, l_af_n, l_ae_n, l_wxo_n, l_rxo_n, l_wt, l_rt, l_rf;
  chain_node #(.W(W), .DEPTH(DEPTH)) i_lead (
    .clk(clk), .rst_n(rst_n), .lead_n(1'b0), .wxi_n(l_wxi), .rxi_n(l_rxi),
    .wr_en(l_wr), .din(l_din), .rd_en(l_rd), .dout(l_dout),
    .full_n(l_full_n), .empty_n(l_empty_n), .almost_full_n(l_af_n),
    .almost_empty_n(l_ae_n), .wxo_hf_n(l_wxo_n), .rxo_n(l_rxo_n),
    .wr_turn(l_wt), .rd_turn(l_rt), .rd_fire(l_rf)
  );

  int solo_rxo_lows = 0;
  always @(negedge clk) if (rst_n && !s_rxo_n) solo_rxo_lows++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model for the chain
  logic [W-1:0] refq[$];
  logic [W-1:0] pend_val;
  bit pend_rd = 1'b0;
  logic [W-1:0] next_word = 8'h10;

  task automatic tick(input bit w, input bit r, output bit wacc, output bit racc);
    @(negedge clk);
    if (pend_rd) begin
      chk(dout == pend_val, "R2 order", int'(dout), int'(pend_val));
      pend_rd = 1'b0;
    end
    wacc = w && full_n;
    racc = r && empty_n;
    wr_en = w;
    rd_en = r;
    din = next_word;
    if (racc) begin
      pend_val = refq.pop_front();
      pend_rd = 1'b1;
    end
    if (wacc) begin
      refq.push_back(next_word);
      next_word = next_word + 8'd1;
    end
  endtask

  task automatic t_reset;
    chk(full_n == 1'b1, "R1 full_n", full_n, 1);
    chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
    chk(ae_n == 1'b0, "R1 almost_empty_n", ae_n, 0);
    chk(af_n == 1'b1, "R1 almost_full_n", af_n, 1);
    chk(dout == '0, "R1 R10 dout", int'(dout), 0);
  endtask

  task automatic t_fill_drain;
    bit wa, ra;
    int acc = 0;
    bit fpat [14];
    bit epat [14];
    for (int i = 0; i < 14; i++) begin
      tick(1'b1, 1'b0, wa, ra);
      fpat[i] = wa;
      if (wa) acc++;
    end
    chk(acc == CAP, "R2 capacity", acc, CAP);
    chk(fpat[4] == 1'b0, "R3 gap after node0", fpat[4], 0);
    chk(fpat[5] == 1'b1, "R3 turn resumes", fpat[5], 1);
    chk(fpat[9] == 1'b0, "R3 gap after node1", fpat[9], 0);
    for (int i = 0; i < 3; i++) begin
      tick(1'b1, 1'b0, wa, ra);
      if (wa) acc++;
    end
    chk(acc == CAP, "R5 write while full dropped", acc, CAP);
    tick(1'b0, 1'b0, wa, ra);
    chk(af_n == 1'b0, "R9 composite almost_full_n", af_n, 0);
    chk(ae_n == 1'b1, "R9 composite almost_empty_n", ae_n, 1);
    chk(full_n == 1'b0, "R9 composite full_n", full_n, 0);
    acc = 0;
    for (int i = 0; i < 14; i++) begin
      tick(1'b0, 1'b1, wa, ra);
      epat[i] = ra;
      if (ra) acc++;
    end
    chk(acc == CAP, "R2 drain count", acc, CAP);
    chk(epat[4] == 1'b0, "R4 gap after node0", epat[4], 0);
    chk(epat[5] == 1'b1, "R4 turn resumes", epat[5], 1);
    tick(1'b0, 1'b1, wa, ra);
    chk(ra == 1'b0, "R5 read while empty dropped", ra, 0);
    tick(1'b0, 1'b0, wa, ra);
    chk(empty_n == 1'b0, "R9 empty after drain", empty_n, 0);
    chk(ae_n == 1'b0, "R9 almost_empty after drain", ae_n, 0);
    chk(refq.size() == 0, "R2 model empty", refq.size(), 0);
  endtask

  task automatic t_mixed;
    bit wa, ra;
    int n = 0;
    int guard = 0;
    while (n < 5 && guard < 20) begin
      tick(1'b1, 1'b0, wa, ra);
      if (wa) n++;
      guard++;
    end
    chk(n == 5, "R2 prefill", n, 5);
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b1, wa, ra);
    guard = 0;
    while (refq.size() > 0 && guard < 40) begin
      tick(1'b0, 1'b1, wa, ra);
      guard++;
    end
    tick(1'b0, 1'b0, wa, ra);
    chk(refq.size() == 0, "R2 mixed drained", refq.size(), 0);
    chk(empty_n == 1'b0, "R9 empty after mixed", empty_n, 0);
  endtask

  task automatic t_solo;
    @(negedge clk);
    chk(s_hf_n == 1'b1, "R8 hf idle", s_hf_n, 1);
    for (int i = 0; i < 2; i++) begin
      s_wr = 1'b1; s_din = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    s_wr = 1'b0;
    chk(s_hf_n == 1'b1, "R8 hf at DEPTH/2", s_hf_n, 1);
    s_wr = 1'b1; s_din = 8'hA2;
    @(negedge clk);
    s_wr = 1'b0;
    chk(s_hf_n == 1'b0, "R8 hf above DEPTH/2", s_hf_n, 0);
    s_rd = 1'b1;
    @(negedge clk);
    s_rd = 1'b0;
    chk(s_dout == 8'hA0, "R10 solo first word", int'(s_dout), 'hA0);
    chk(s_hf_n == 1'b1, "R8 hf back high", s_hf_n, 1);
    for (int i = 3; i < 6; i++) begin
      s_wr = 1'b1; s_din = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    s_wr = 1'b0;
    chk(s_full_n == 1'b0, "R8 solo full", s_full_n, 0);
    for (int i = 1; i < 5; i++) begin
      s_rd = 1'b1;
      @(negedge clk);
      chk(s_dout == 8'hA0 + 8'(i), "R5 R8 solo order", int'(s_dout), 'hA0 + i);
    end
    s_rd = 1'b0;
    @(negedge clk);
    chk(s_empty_n == 1'b0, "R8 solo empty", s_empty_n, 0);
    chk(s_dout == 8'hA4, "R10 solo dout holds", int'(s_dout), 'hA4);
    chk(solo_rxo_lows == 0, "R8 no read pulse on wrap", solo_rxo_lows, 0);
  endtask

  task automatic t_lead;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      l_wr = 1'b1; l_din = 8'hC0 + 8'(i);
    end
    @(negedge clk);
    l_wr = 1'b0;
    chk(l_wxo_n == 1'b0, "R6 write pulse low", l_wxo_n, 0);
    chk(l_full_n == 1'b0, "R6 turn released", l_full_n, 0);
    chk(l_af_n == 1'b0, "R9 node almost_full", l_af_n, 0);
    @(negedge clk);
    chk(l_wxo_n == 1'b1, "R6 pulse one cycle", l_wxo_n, 1);
    for (int i = 0; i < DEPTH; i++) begin
      l_rd = 1'b1;
      @(negedge clk);
      chk(l_dout == 8'hC0 + 8'(i), "R7 lead order", int'(l_dout), 'hC0 + i);
      if (i == DEPTH - 1) chk(l_rxo_n == 1'b0, "R7 read pulse low", l_rxo_n, 0);
    end
    l_rd = 1'b0;
    @(negedge clk);
    chk(l_rxo_n == 1'b1, "R7 pulse one cycle", l_rxo_n, 1);
    chk(l_full_n == 1'b0, "R6 still waiting for turn", l_full_n, 0);
    l_wr = 1'b1; l_din = 8'hEE;
    @(negedge clk);
    l_wr = 1'b0;
    chk(l_ae_n == 1'b0, "R6 write without turn dropped", l_ae_n, 0);
    l_wxi = 1'b0;
    @(negedge clk);
    l_wxi = 1'b1;
    chk(l_full_n == 1'b1, "R6 turn regained", l_full_n, 1);
    chk(l_empty_n == 1'b0, "R7 no read turn yet", l_empty_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_mixed();
    t_solo();
    t_lead();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule